// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Core

This block keeps one processor's interrupt state for 256 vectors: a pending-request set, an in-service set and a per-vector trigger-kind set (level or edge). Incoming vectored requests arrive on a valid/ready stream. The block combines a software-written task priority with the highest vector in service into a processor priority. Requests whose 16-vector priority class is not above that priority are held back. An interrupt line tells the processor that a serviceable request exists. An acknowledge strobe hands over the vector to run and moves it from pending to in-service.

Software reaches the block through a simple 32-bit register bus. The register index is taken from address bits 11:4. Writing the end-of-interrupt index retires the most urgent in-service vector. If that vector was level-triggered, the block sends a one-cycle notice outward so that the source can re-evaluate its line. A separate drop input withdraws a pending request when a level source releases its line.

The request stream never applies back-pressure: `req_ready` is held high, and every cycle with `req_valid` high accepts one request. Drop, acknowledge and bus strobes are plain single-cycle controls. Reads return data in the same cycle as `bus_rd`. Every state change takes effect at the next rising clock edge, and `irq_out` and `ack_vector` follow the new state at once. Where events coincide in one cycle, setting a request wins over clearing it, and an end-of-interrupt clear of a vector wins over an acknowledge that sets the same vector.

Top module: `prio_vec_intc`

## Requirements
- R1: `req_ready` is always 1. A cycle with `req_valid` high sets pending bit `req_vector`. It also sets that vector's trigger bit if `req_level` is 1 and clears it if `req_level` is 0. Vector v sits in word v>>5, bit v&31 of every 256-bit set.
- R2: A cycle with `drop_valid` high clears pending bit `drop_vector`, unless a request for the same vector arrives in the same cycle.
- R3: The most urgent vector of a set is its highest-numbered set bit. Let C be the class (bits 7:4) of the most urgent in-service vector, with C = 0 when nothing is in service. The processor priority equals the task priority when task-priority bits 7:4 are >= C, and equals C<<4 otherwise. It reads at index 0x0A.
- R4: `irq_out` is 1 exactly when all three of these hold: enable bit 8 of the spurious register is 1, some request is pending, and the most urgent pending vector is unmasked. That vector is masked when the processor priority is nonzero and the vector's class is <= the priority class.
- R5: `ack` while `irq_out` is 1 returns the most urgent pending vector on `ack_vector` in the same cycle. At the next edge it clears that vector's pending bit and sets its in-service bit.
- R6: `ack` while `irq_out` is 0 returns spurious-register bits 7:0 and changes neither the pending set nor the in-service set.
- R7: A write to index 0x0B clears the most urgent in-service bit. The cycle after the write, `eoi_valid` pulses for one cycle with `eoi_vector` equal to that vector, if the vector's trigger bit is 1 and bit 12 of the spurious register is 0. Otherwise no pulse occurs. Index 0x0B reads as 0.
- R8: Index 0x08 holds the 8-bit task priority (read/write). Index 0x0F holds the spurious register, whose writable mask is 0x11FF. Indices 0x10-0x17 read the in-service words, 0x18-0x1F the trigger words and 0x20-0x27 the pending words, word n at index base+n.
- R9: A read or write of any index outside {0x08, 0x0A, 0x0B, 0x0F, 0x10-0x28} reads 0 and sets bit 7 of the error register at index 0x28. Writes to 0x0A and 0x10-0x28 change nothing.
- R10: A synchronous reset (`rst` high) clears all three vector sets, the task priority and the error register, and sets the spurious register to 0x0FF. This leaves the block disabled with `irq_out` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always 1; request accepted each valid cycle |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge |
| drop_valid | input | 1 | Level source released its line |
| drop_vector | input | 8 | Vector whose request is withdrawn |
| irq_out | output | 1 | Serviceable request exists |
| ack | input | 1 | Processor acknowledge strobe |
| ack_vector | output | 8 | Vector returned for an acknowledge |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address; bits 11:4 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| eoi_valid | output | 1 | Level end-of-interrupt notice |
| eoi_vector | output | 8 | Vector retired by that notice |

## Verification
The bench first drives isolated requests, including those that arrive while the block is disabled, to separate enable gating from masking. It then creates pairs of requests in different classes, which shows whether urgency is decided by vector number and whether in-service state masks lower classes. Task-priority writes at and just below a request's class test the at-or-below masking boundary. End-of-interrupt writes follow level requests, edge requests and requests with the directed bit set, so the notice logic sees every combination. A long stream of scattered vectors mixed with acknowledges and retirements is then run against a behavioural model on every clock.

// File: rtl/pvi_pkg.sv
package pvi_pkg;
  localparam logic [7:0] IDX_TPR  = 8'h08;
  localparam logic [7:0] IDX_PPR  = 8'h0A;
  localparam logic [7:0] IDX_EOI  = 8'h0B;
  localparam logic [7:0] IDX_SVR  = 8'h0F;
  localparam logic [7:0] IDX_ISR0 = 8'h10;
  localparam logic [7:0] IDX_TMR0 = 8'h18;
  localparam logic [7:0] IDX_IRR0 = 8'h20;
  localparam logic [7:0] IDX_ERR  = 8'h28;
  localparam int         SVR_W    = 13;
  localparam logic [SVR_W-1:0] SVR_WMASK = 13'h11FF;
  localparam logic [SVR_W-1:0] SVR_RST   = 13'h00FF;
  localparam int         SVR_EN_BIT  = 8;
  localparam int         SVR_DIR_BIT = 12;
endpackage

// File: rtl/pvi_hifind.sv
module pvi_hifind #(
  parameter int N = 256,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  output logic [IW-1:0] idx,
  output logic          none
);
  always_comb begin
    idx  = '0;
    none = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) begin
        idx  = IW'(i);
        none = 1'b0;
      end
    end
  end
endmodule

// File: rtl/pvi_prio.sv
module pvi_prio #(
  parameter int VW = 8,
  localparam int CLS_LSB = 4
) (
  input  logic [VW-1:0] tpr,
  input  logic [VW-1:0] isr_top,
  input  logic          isr_none,
  output logic [VW-1:0] ppr
);
  logic [VW-1-CLS_LSB:0] isr_cls;
  always_comb begin
    isr_cls = isr_none ? '0 : isr_top[VW-1:CLS_LSB];
    if (tpr[VW-1:CLS_LSB] >= isr_cls) ppr = tpr;
    else                              ppr = {isr_cls, {CLS_LSB{1'b0}}};
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int VEC_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VEC_W-1:0]  req_vector,
  input  logic              req_level,
  input  logic              drop_valid,
  input  logic [VEC_W-1:0]  drop_vector,
  output logic              irq_out,
  input  logic              ack,
  output logic [VEC_W-1:0]  ack_vector,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              eoi_valid,
  output logic [VEC_W-1:0]  eoi_vector
);
  import pvi_pkg::*;

  localparam int NV     = 1 << VEC_W;
  localparam int NWORDS = NV / DATA_W;
  localparam int WSEL   = $clog2(NWORDS);
  localparam int CLS    = 4;
  localparam int RIW    = ADDR_W - 4;

  logic [NV-1:0]      irr, isr, tmr;
  logic [VEC_W-1:0]   tpr;
  logic [SVR_W-1:0]   svr;
  logic               err_ill;

  logic [VEC_W-1:0]   irr_top, isr_top, ppr;
  logic               irr_none, isr_none;
  logic [RIW-1:0]     ridx;
  logic [WSEL-1:0]    wsel;
  logic               in_isr, in_tmr, in_irr, idx_def;
  logic               pending, take, eoi_wr, eoi_hit;
  logic [NV-1:0]      set_oh, take_oh, drop_oh, eoi_oh;
  logic               unused_bits;

  assign unused_bits = ^{bus_addr[3:0], bus_wdata[DATA_W-1:SVR_W]};

  pvi_hifind #(.N(NV)) u_irr_top (.bits(irr), .idx(irr_top), .none(irr_none));
  pvi_hifind #(.N(NV)) u_isr_top (.bits(isr), .idx(isr_top), .none(isr_none));
  pvi_prio   #(.VW(VEC_W)) u_prio (.tpr(tpr), .isr_top(isr_top), .isr_none(isr_none), .ppr(ppr));

  assign req_ready = 1'b1;

  // masking by priority class against processor priority
  always_comb begin
    pending = svr[SVR_EN_BIT] && !irr_none;
    if ((ppr != '0) && (irr_top[VEC_W-1:CLS] <= ppr[VEC_W-1:CLS])) pending = 1'b0;
  end
  assign irq_out    = pending;
  assign take       = ack && pending;
  assign ack_vector = pending ? irr_top : svr[VEC_W-1:0];

  // register decode
  assign ridx    = bus_addr[ADDR_W-1:4];
  assign wsel    = ridx[WSEL-1:0];
  assign in_isr  = (ridx >= IDX_ISR0) && (ridx < IDX_TMR0);
  assign in_tmr  = (ridx >= IDX_TMR0) && (ridx < IDX_IRR0);
  assign in_irr  = (ridx >= IDX_IRR0) && (ridx < IDX_ERR);
  assign idx_def = (ridx == IDX_TPR) || (ridx == IDX_PPR) || (ridx == IDX_EOI) ||
                   (ridx == IDX_SVR) || in_isr || in_tmr || in_irr || (ridx == IDX_ERR);

  always_comb begin
    bus_rdata = '0;
    if (ridx == IDX_TPR)      bus_rdata = DATA_W'(tpr);
    else if (ridx == IDX_PPR) bus_rdata = DATA_W'(ppr);
    else if (ridx == IDX_SVR) bus_rdata = DATA_W'(svr);
    else if (in_isr)          bus_rdata = isr[DATA_W*int'(wsel) +: DATA_W];
    else if (in_tmr)          bus_rdata = tmr[DATA_W*int'(wsel) +: DATA_W];
    else if (in_irr)          bus_rdata = irr[DATA_W*int'(wsel) +: DATA_W];
    else if (ridx == IDX_ERR) bus_rdata = DATA_W'({err_ill, 7'b0});
  end

  // state update masks
  assign eoi_wr  = bus_wr && (ridx == IDX_EOI);
  assign eoi_hit = eoi_wr && !isr_none;
  assign set_oh  = req_valid  ? (NV'(1) << req_vector)  : '0;
  assign drop_oh = drop_valid ? (NV'(1) << drop_vector) : '0;
  assign take_oh = take       ? (NV'(1) << irr_top)     : '0;
  assign eoi_oh  = eoi_hit    ? (NV'(1) << isr_top)     : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      irr        <= '0;
      isr        <= '0;
      tmr        <= '0;
      tpr        <= '0;
      svr        <= SVR_RST;
      err_ill    <= 1'b0;
      eoi_valid  <= 1'b0;
      eoi_vector <= '0;
    end else begin
      irr <= (irr & ~take_oh & ~drop_oh) | set_oh;
      isr <= (isr | take_oh) & ~eoi_oh;
      if (req_valid) tmr[req_vector] <= req_level;
      if (bus_wr && ridx == IDX_TPR) tpr <= bus_wdata[VEC_W-1:0];
      if (bus_wr && ridx == IDX_SVR) svr <= bus_wdata[SVR_W-1:0] & SVR_WMASK;
      if ((bus_wr || bus_rd) && !idx_def) err_ill <= 1'b1;
      eoi_valid  <= eoi_hit && tmr[isr_top] && !svr[SVR_DIR_BIT];
      eoi_vector <= isr_top;
    end
  end

  a_r1_req_sets: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> irr[$past(req_vector)] && (tmr[$past(req_vector)] == $past(req_level)));
  a_r2_drop_clears: assert property (@(posedge clk) disable iff (rst)
    drop_valid && !(req_valid && req_vector == drop_vector) |=> !irr[$past(drop_vector)]);
  a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> svr[SVR_EN_BIT]);
  a_r5_ack_in_service: assert property (@(posedge clk) disable iff (rst)
    ack && irq_out && !bus_wr |=> isr[$past(ack_vector)]);
  a_r6_spurious_still: assert property (@(posedge clk) disable iff (rst)
    ack && !irq_out && !req_valid && !drop_valid && !bus_wr |=> $stable(irr) && $stable(isr));
  a_r7_eoi_from_write: assert property (@(posedge clk) disable iff (rst)
    eoi_valid |-> $past(bus_wr) && ($past(ridx) == IDX_EOI));
  a_r10_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (svr == SVR_RST) && (irr == '0) && (isr == '0) && !irq_out);
endmodule

// File: tb/tb_prio_vec_intc.sv
module tb_prio_vec_intc;
  logic clk = 0, rst = 1;
  logic req_valid = 0, req_level = 0, drop_valid = 0, ack = 0;
  logic [7:0] req_vector = 0, drop_vector = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic req_ready, irq_out, eoi_valid;
  logic [7:0] ack_vector, eoi_vector;
  logic [31:0] bus_rdata;

  always #2 clk = ~clk;

  prio_vec_intc dut (.clk, .rst, .req_valid, .req_ready, .req_vector, .req_level,
    .drop_valid, .drop_vector, .irq_out, .ack, .ack_vector, .bus_wr, .bus_rd,
    .bus_addr, .bus_wdata, .bus_rdata, .eoi_valid, .eoi_vector);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string tag = "R8";

  logic [255:0] m_irr, m_isr, m_tmr;
  int m_tpr, m_svr;
  bit m_err, m_eoi_v;
  int m_eoi_vec;

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  function automatic int top(input logic [255:0] s);
    for (int i = 255; i >= 0; i--) if (s[i]) return i;
    return -1;
  endfunction

  function automatic int m_ppr();
    int t = top(m_isr);
    int c = (t < 0) ? 0 : (t >> 4);
    return ((m_tpr >> 4) >= c) ? m_tpr : (c << 4);
  endfunction

  function automatic bit m_pend();
    int t = top(m_irr);
    int p = m_ppr();
    if (!m_svr[8] || t < 0) return 0;
    if (p != 0 && (t >> 4) <= (p >> 4)) return 0;
    return 1;
  endfunction

  function automatic bit defd(input int ix);
    return ix == 8'h08 || ix == 8'h0A || ix == 8'h0B || ix == 8'h0F ||
           (ix >= 8'h10 && ix <= 8'h28);
  endfunction

  function automatic logic [31:0] m_read(input int ix);
    if (ix == 8'h08) return m_tpr;
    if (ix == 8'h0A) return m_ppr();
    if (ix == 8'h0F) return m_svr;
    if (ix >= 8'h10 && ix < 8'h18) return m_isr[32*(ix-8'h10) +: 32];
    if (ix >= 8'h18 && ix < 8'h20) return m_tmr[32*(ix-8'h18) +: 32];
    if (ix >= 8'h20 && ix < 8'h28) return m_irr[32*(ix-8'h20) +: 32];
    if (ix == 8'h28) return m_err ? 32'h80 : 32'h0;
    return 0;
  endfunction

  // one clock: compare outputs, advance model
  task automatic cyc();
    bit p; int vt, it, ix;
    #1;
    p = m_pend(); vt = top(m_irr); it = top(m_isr); ix = bus_addr[11:4];
    chk("R4 irq_out", irq_out, p);
    chk("R1 req_ready", req_ready, 1);
    chk("R7 eoi_valid", eoi_valid, m_eoi_v);
    if (m_eoi_v) chk("R7 eoi_vector", eoi_vector, m_eoi_vec);
    if (ack) chk(p ? "R5 ack_vector" : "R6 ack_vector", ack_vector, p ? vt : (m_svr & 8'hFF));
    if (bus_rd) chk(tag, bus_rdata, m_read(ix));
    m_eoi_v = 0;
    if (bus_wr && ix == 8'h0B && it >= 0) begin
      m_eoi_v = m_tmr[it] && !m_svr[12];
      m_eoi_vec = it;
    end
    if (ack && p) begin m_irr[vt] = 0; m_isr[vt] = 1; end
    if (bus_wr && ix == 8'h0B && it >= 0) m_isr[it] = 0;
    if (drop_valid) m_irr[drop_vector] = 0;
    if (req_valid) begin m_irr[req_vector] = 1; m_tmr[req_vector] = req_level; end
    if (bus_wr && ix == 8'h08) m_tpr = bus_wdata[7:0];
    if (bus_wr && ix == 8'h0F) m_svr = bus_wdata & 32'h11FF;
    if ((bus_wr || bus_rd) && !defd(ix)) m_err = 1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(); cyc(); endtask
  task automatic rq(input int v, input bit l);
    req_valid = 1; req_vector = 8'(v); req_level = l; cyc(); req_valid = 0;
  endtask
  task automatic dr(input int v);
    drop_valid = 1; drop_vector = 8'(v); cyc(); drop_valid = 0;
  endtask
  task automatic ak(); ack = 1; cyc(); ack = 0; endtask
  task automatic wr(input int ix, input int d);
    bus_wr = 1; bus_addr = {4'(ix >> 4), 4'(ix), 4'h0}; bus_wdata = d; cyc(); bus_wr = 0;
  endtask
  task automatic rd(input string t, input int ix);
    tag = t; bus_rd = 1; bus_addr = {4'(ix >> 4), 4'(ix), 4'h0}; cyc(); bus_rd = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    m_irr = 0; m_isr = 0; m_tmr = 0; m_tpr = 0; m_svr = 32'hFF; m_err = 0;
    m_eoi_v = 0; m_eoi_vec = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    rd("R10 spurious reset", 8'h0F);
    rd("R10 tpr reset", 8'h08);
    rd("R10 irr reset", 8'h21);
    // disabled: request held but no irq
    rq(8'h35, 0);
    rd("R1 irr word1", 8'h21);
    idle();
    wr(8'h0F, 32'h1FF);                 // R4 enable
    idle();
    rq(8'h62, 1);
    rd("R1 tmr level bit", 8'h1B);
    ak();                               // R5 returns 0x62
    rd("R5 isr word3", 8'h13);
    rd("R3 ppr from isr", 8'h0A);
    ak();                               // R6 masked -> spurious
    rd("R6 irr intact", 8'h21);
    rd("R6 isr intact", 8'h13);
    wr(8'h0B, 0);                       // R7 level -> notice
    idle();
    rd("R7 isr cleared", 8'h13);
    wr(8'h08, 32'h40);                  // R3 task priority
    rd("R3 ppr from tpr", 8'h0A);
    rq(8'h45, 0); idle();               // R4 class equal -> masked
    rq(8'h51, 0); idle();               // R4 above -> irq
    ak();
    rd("R3 ppr isr wins", 8'h0A);
    wr(8'h0B, 0); idle();               // R7 edge -> no notice
    wr(8'h08, 0); idle();
    ak(); ak(); ak();
    wr(8'h0B, 0); wr(8'h0B, 0); wr(8'h0B, 0); idle();
    wr(8'h0F, 32'hFFFF11FF);            // R8 directed bit, mask
    rd("R8 spurious mask", 8'h0F);
    rq(8'h77, 1); ak(); wr(8'h0B, 0); idle(); // R7 directed -> no notice
    wr(8'h0F, 32'h1FF);
    rq(8'h62, 0);
    rd("R1 tmr edge clear", 8'h1B);
    rq(8'h90, 1); idle();
    dr(8'h90);                          // R2
    rd("R2 irr dropped", 8'h24);
    rd("R9 undefined reads zero", 8'h05);
    rd("R9 error bit", 8'h28);
    wr(8'h20, 32'hFFFFFFFF);
    rd("R9 irr write ignored", 8'h20);
    wr(8'h0A, 32'hFF);
    rd("R9 ppr write ignored", 8'h0A);
    ak(); wr(8'h0B, 0); idle();
    // scattered stream against the model
    for (int i = 0; i < 200; i++) begin
      req_valid = (i % 3) != 2; req_vector = 8'((i * 37 + 11) & 255); req_level = i[1];
      ack = (i % 4) == 1;
      bus_wr = (i % 5) == 3; bus_addr = 12'h0B0;
      if ((i % 23) == 7) begin bus_addr = 12'h080; bus_wdata = (i * 13) & 255; end
      drop_valid = (i % 7) == 4; drop_vector = 8'((i * 53) & 255);
      cyc();
    end
    req_valid = 0; ack = 0; bus_wr = 0; drop_valid = 0;
    rd("R8 irr word after stream", 8'h27);
    rd("R8 tmr word after stream", 8'h1C);
    idle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule